// File: doc/BRIEF.md
# Software Interrupt Signal Register Pair

This block holds four interrupt source flags and their enables behind two byte-wide registers on a simple local I/O bus. Two of the flags are software signals. The other two are location-monitor flags, which dedicated hardware hit pulses can also set. Software changes a flag only through the command register. In one write, each of its upper four bits sets one flag and each of its lower four bits clears one flag. A zero bit leaves its flag alone. The command register always reads back as zero.

The status register combines two things. Its upper nibble holds four enables that software can read and write. Its lower nibble shows the four flags, read-only. Each of the two interrupt outputs is registered and level-sensitive. Each is the OR of one signal flag and one monitor flag, each gated by its own enable. Software raises an interrupt toward the local processor by setting a flag. It acknowledges the interrupt by clearing that flag.

Top module: `swi_flag_regs`

## Requirements
- R1: After a synchronous reset the status register reads 0x00 and both interrupt outputs are low.
- R2: A write to the command register (offset 0x1000) with bit 7, 6, 5 or 4 set sets flag SIG1, SIG0, LM1 or LM0 respectively. The flags occupy status bits 3, 2, 1 and 0, and the new value is readable in the cycle after the write edge.
- R3: A command write with bit 3, 2, 1 or 0 set clears flag SIG1, SIG0, LM1 or LM0 respectively.
- R4: When one command write both sets and clears the same flag, the flag ends cleared.
- R5: Zero bits in a command write leave their flags unchanged, and a read of the command register returns 0x00.
- R6: A write to the status register (offset 0x1001) loads bits 7..4 into the enables EN_SIG1, EN_SIG0, EN_LM1 and EN_LM0. Bits 3..0 of that write are ignored, and a status read returns {enables, flags}.
- R7: Output irq1 equals (EN_SIG1 AND SIG1) OR (EN_LM1 AND LM1), as sampled one clock earlier.
- R8: Output irq0 equals (EN_SIG0 AND SIG0) OR (EN_LM0 AND LM0), as sampled one clock earlier.
- R9: A one-cycle pulse on lm0_hit or lm1_hit sets LM0 or LM1. When the pulse coincides with a command clear of the same flag, the flag ends set.
- R10: Writes to any other address, and any access with bus_sel low, change no state. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| lm0_hit | input | 1 | Pulse that sets monitor flag LM0 |
| lm1_hit | input | 1 | Pulse that sets monitor flag LM1 |
| irq0 | output | 1 | Interrupt line 0 (SIG0 / LM0) |
| irq1 | output | 1 | Interrupt line 1 (SIG1 / LM1) |

## Verification
A flag or enable change caused by a write or a hit pulse becomes visible on a status read in the cycle that follows the write edge. The matching interrupt output moves one edge later still, because the output is registered from the flags. The bench drives every input at the falling edge and lets one rising edge pass. At the next falling edge it compares read data against a reference model that advances on the same edge. It compares each interrupt against a copy of the model's gate result registered one edge behind. The directed part checks explicitly that an interrupt is still low in the cycle where its flag first reads as set.

// File: rtl/swi_flag_pkg.sv
package swi_flag_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int NUM_HITS  = 2;

    // bit positions of the flags in the status byte and command nibbles
    typedef enum logic [1:0] {
        FL_LM0  = 2'd0,
        FL_LM1  = 2'd1,
        FL_SIG0 = 2'd2,
        FL_SIG1 = 2'd3
    } flag_idx_e;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] set_bits;
        logic [NUM_FLAGS-1:0] clr_bits;
    } cmd_word_t;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] enables;
        logic [NUM_FLAGS-1:0] flags;
    } stat_word_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CMD  = 2'd1,
        TGT_STAT = 2'd2
    } reg_tgt_e;

    // priority: hardware hit, then clear, then set, then hold
    function automatic logic flag_next(input logic cur, input logic set_b,
                                       input logic clr_b, input logic hit_b);
        logic nxt;
        if (hit_b)      nxt = 1'b1;
        else if (clr_b) nxt = 1'b0;
        else if (set_b) nxt = 1'b1;
        else            nxt = cur;
        return nxt;
    endfunction

    // returns {line1, line0}
    function automatic logic [1:0] irq_of(input stat_word_t s);
        logic l1;
        logic l0;
        l1 = (s.enables[FL_SIG1] & s.flags[FL_SIG1]) |
             (s.enables[FL_LM1]  & s.flags[FL_LM1]);
        l0 = (s.enables[FL_SIG0] & s.flags[FL_SIG0]) |
             (s.enables[FL_LM0]  & s.flags[FL_LM0]);
        return {l1, l0};
    endfunction

endpackage

// File: rtl/swi_addr_decode.sv
module swi_addr_decode
    import swi_flag_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(16'h1000),
    parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(16'h1001)
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_cmd,
    output logic              wr_stat,
    output logic              rd_stat
);

    reg_tgt_e tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (bus_sel) begin
            if (bus_addr == CMD_OFS)       tgt = TGT_CMD;
            else if (bus_addr == STAT_OFS) tgt = TGT_STAT;
        end
    end

    assign wr_cmd  = (tgt == TGT_CMD)  &&  bus_we;
    assign wr_stat = (tgt == TGT_STAT) &&  bus_we;
    assign rd_stat = (tgt == TGT_STAT) && !bus_we;

endmodule

// File: rtl/swi_flag_cell.sv
module swi_flag_cell
    import swi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic hit_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= flag_next(q_o, set_i, clr_i, hit_i);
    end

endmodule

// File: rtl/swi_irq_gate.sv
module swi_irq_gate
    import swi_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stat_word_t stat_i,
    output logic       irq0_o,
    output logic       irq1_o
);

    logic [1:0] lines;

    assign lines = irq_of(stat_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq0_o <= 1'b0;
            irq1_o <= 1'b0;
        end else begin
            irq0_o <= lines[0];
            irq1_o <= lines[1];
        end
    end

endmodule

// File: rtl/swi_flag_regs.sv
module swi_flag_regs
    import swi_flag_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(16'h1000),
    parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(16'h1001)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              lm0_hit,
    input  logic              lm1_hit,
    output logic              irq0,
    output logic              irq1
);

    localparam int SPARE = NUM_FLAGS - NUM_HITS;

    logic                 wr_cmd;
    logic                 wr_stat;
    logic                 rd_stat;
    cmd_word_t            cmd;
    stat_word_t           stat_q;
    logic [NUM_FLAGS-1:0] en_q;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] hit_vec;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;

    swi_addr_decode #(
        .ADDR_W  (ADDR_W),
        .CMD_OFS (CMD_OFS),
        .STAT_OFS(STAT_OFS)
    ) dec_i (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .wr_cmd  (wr_cmd),
        .wr_stat (wr_stat),
        .rd_stat (rd_stat)
    );

    assign cmd     = cmd_word_t'(bus_wdata);
    assign set_vec = wr_cmd ? cmd.set_bits : '0;
    assign clr_vec = wr_cmd ? cmd.clr_bits : '0;
    assign hit_vec = {{SPARE{1'b0}}, lm1_hit, lm0_hit};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        swi_flag_cell cell_i (
            .clk  (clk),
            .rst  (rst),
            .set_i(set_vec[i]),
            .clr_i(clr_vec[i]),
            .hit_i(hit_vec[i]),
            .q_o  (flag_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          en_q <= '0;
        else if (wr_stat) en_q <= bus_wdata[7:4];
    end

    assign stat_q.enables = en_q;
    assign stat_q.flags   = flag_q;

    assign bus_rdata = rd_stat ? stat_q : 8'h00;

    swi_irq_gate gate_i (
        .clk   (clk),
        .rst   (rst),
        .stat_i(stat_q),
        .irq0_o(irq0),
        .irq1_o(irq1)
    );

endmodule

// File: rtl/swi_flag_regs_chk.sv
module swi_flag_regs_chk #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(16'h1000),
    parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(16'h1001)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              lm0_hit,
    input logic              lm1_hit,
    input logic              irq0,
    input logic              irq1,
    input logic [7:0]        stat_q
);

    logic cmd_wr;
    logic stat_wr;
    logic other_wr;

    assign cmd_wr   = bus_sel && bus_we && (bus_addr == CMD_OFS);
    assign stat_wr  = bus_sel && bus_we && (bus_addr == STAT_OFS);
    assign other_wr = bus_sel && bus_we && (bus_addr != CMD_OFS) && (bus_addr != STAT_OFS);

    // R4
    set_clr_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata[7] && bus_wdata[3]) |=> !stat_q[3]);

    // R5
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == CMD_OFS) |-> (bus_rdata == 8'h00));

    // R6
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> (stat_q[7:4] == $past(bus_wdata[7:4])));

    // R7
    irq1_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq1 == $past((stat_q[7] & stat_q[3]) | (stat_q[5] & stat_q[1]))));

    // R8
    irq0_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq0 == $past((stat_q[6] & stat_q[2]) | (stat_q[4] & stat_q[0]))));

    // R9
    lm0_hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
        lm0_hit |=> stat_q[0]);

    // R9
    lm1_hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
        lm1_hit |=> stat_q[1]);

    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
        (other_wr && !lm0_hit && !lm1_hit) |=> $stable(stat_q));

endmodule

bind swi_flag_regs swi_flag_regs_chk #(
    .ADDR_W  (ADDR_W),
    .CMD_OFS (CMD_OFS),
    .STAT_OFS(STAT_OFS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .lm0_hit  (lm0_hit),
    .lm1_hit  (lm1_hit),
    .irq0     (irq0),
    .irq1     (irq1),
    .stat_q   (stat_q)
);

// File: tb/swi_flag_regs_tb_top.sv
module swi_flag_regs_tb_top;

    localparam logic [15:0] CMD_A  = 16'h1000;
    localparam logic [15:0] STAT_A = 16'h1001;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        lm0_hit;
    logic        lm1_hit;
    logic        irq0;
    logic        irq1;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    swi_flag_regs dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lm0_hit  (lm0_hit),
        .lm1_hit  (lm1_hit),
        .irq0     (irq0),
        .irq1     (irq1)
    );

    // reference model built from the requirements
    logic [3:0] m_en;
    logic [3:0] m_flag;
    logic       m_irq0;
    logic       m_irq1;

    function automatic logic m_bit(input logic cur, input logic s, input logic c, input logic h);
        if (h) return 1'b1;
        if (c) return 1'b0;
        if (s) return 1'b1;
        return cur;
    endfunction

    function automatic logic [7:0] m_read(input logic [15:0] a);
        if (a == STAT_A) return {m_en, m_flag};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic       wc;
        logic [3:0] hv;
        logic [3:0] nf;
        if (rst) begin
            m_en   <= 4'h0;
            m_flag <= 4'h0;
            m_irq0 <= 1'b0;
            m_irq1 <= 1'b0;
        end else begin
            m_irq1 <= (m_en[3] & m_flag[3]) | (m_en[1] & m_flag[1]);
            m_irq0 <= (m_en[2] & m_flag[2]) | (m_en[0] & m_flag[0]);
            wc = bus_sel && bus_we && bus_addr == CMD_A;
            hv = {2'b00, lm1_hit, lm0_hit};
            for (int i = 0; i < 4; i++)
                nf[i] = m_bit(m_flag[i], wc & bus_wdata[i+4], wc & bus_wdata[i], hv[i]);
            m_flag <= nf;
            if (bus_sel && bus_we && bus_addr == STAT_A) m_en <= bus_wdata[7:4];
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at falling edge, check at the next falling edge
    task automatic cyc(input logic s, input logic w, input logic [15:0] a,
                       input logic [7:0] d, input logic h0, input logic h1);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        lm0_hit = h0; lm1_hit = h1;
        @(posedge clk);
        @(negedge clk);
        check("R7", {7'd0, irq1}, {7'd0, m_irq1});
        check("R8", {7'd0, irq0}, {7'd0, m_irq0});
        if (s && !w) check("R2 model read", bus_rdata, m_read(a));
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [15:0] a);
        cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        lm0_hit = 0; lm1_hit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(STAT_A);
        check("R1", bus_rdata, 8'h00);
        check("R1", {6'd0, irq1, irq0}, 8'h00);

        // R2: set all four flags
        wr(CMD_A, 8'hF0); rd(STAT_A);
        check("R2", bus_rdata, 8'h0F);

        // R3: clear SIG0 and LM0
        wr(CMD_A, 8'h05); rd(STAT_A);
        check("R3", bus_rdata, 8'h0A);

        // R4: set and clear together, clear wins
        wr(CMD_A, 8'h88); rd(STAT_A);
        check("R4", bus_rdata, 8'h02);
        wr(CMD_A, 8'h44); rd(STAT_A);
        check("R4", bus_rdata, 8'h02);

        // R5: command reads zero, zero bits do nothing
        rd(CMD_A);
        check("R5", bus_rdata, 8'h00);
        wr(CMD_A, 8'h00); rd(STAT_A);
        check("R5", bus_rdata, 8'h02);

        // R6: enables load, flag bits of the write ignored
        wr(STAT_A, 8'hA5);
        check("R7 lag", {7'd0, irq1}, 8'h00);
        rd(STAT_A);
        check("R6", bus_rdata, 8'hA2);
        check("R7", {7'd0, irq1}, 8'h01);

        // R8: SIG0 set but disabled, then enabled
        wr(CMD_A, 8'h40); rd(STAT_A); rd(STAT_A);
        check("R8 disabled", {7'd0, irq0}, 8'h00);
        wr(STAT_A, 8'h40); rd(STAT_A);
        check("R8", {6'd0, irq1, irq0}, 8'h01);
        check("R6", bus_rdata, 8'h46);

        // R9: hit beats a simultaneous clear; lone hit sets
        cyc(1'b1, 1'b1, CMD_A, 8'h01, 1'b1, 1'b0); rd(STAT_A);
        check("R9", bus_rdata, 8'h47);
        wr(CMD_A, 8'h02); rd(STAT_A);
        check("R9 pre", bus_rdata, 8'h45);
        cyc(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b1); rd(STAT_A);
        check("R9", bus_rdata, 8'h47);

        // R10: foreign address and deselected writes ignored
        wr(16'h1002, 8'hFF); rd(STAT_A);
        check("R10", bus_rdata, 8'h47);
        rd(16'h1002);
        check("R10", bus_rdata, 8'h00);
        cyc(1'b0, 1'b1, CMD_A, 8'hFF, 1'b0, 1'b0); rd(STAT_A);
        check("R10", bus_rdata, 8'h47);
        cyc(1'b0, 1'b1, STAT_A, 8'h00, 1'b0, 1'b0); rd(STAT_A);
        check("R10", bus_rdata, 8'h47);

        // constrained random traffic against the model
        void'($urandom(32'h5EED_0001));
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 7));
            if (pick < 3)      a = CMD_A;
            else if (pick < 6) a = STAT_A;
            else               a = 16'($urandom);
            cyc(($urandom_range(0, 3) != 0), 1'($urandom), a, 8'($urandom),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
        end

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(STAT_A);
        check("R1", bus_rdata, 8'h00);
        check("R1", {6'd0, irq1, irq0}, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule